// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block turns a one-cycle register request (read or write, a 16-bit register address and 16-bit write data) into a sequence of phases on a PHY control-register port. Every access starts with an address phase. A read then uses one read phase. A write uses a data-capture phase and then a commit phase. Each phase presents a value on the port's data field with all strobes low for a settling window. It then raises exactly one strobe and completes a four-phase handshake on the acknowledge line: it waits for acknowledge high, drops the strobe and waits for acknowledge low.

Acknowledge is not watched continuously. It is polled: once when a wait begins, and then every `POLL_INTERVAL` clock cycles. If a wait sees no matching level within `POLL_LIMIT` polls, the access is abandoned. On abandonment all strobes go low, the read result is cleared and an error pulse is given. A host sequencer or init engine issues requests one at a time, waiting for `done` or `err` before issuing the next.

Top module: `phy_cr_master`

## Requirements
- R1: The control word `cr_ctrl` carries the address-capture strobe at bit 19, the data-capture strobe at bit 18, the data field at bits 17:2, the read strobe at bit 1 and the write-commit strobe at bit 0. In `cr_resp`, acknowledge is bit 16 and the PHY read value is bits 15:0.
- R2: After reset, `cr_ctrl`, `busy`, `done`, `err` and `rd_data` are all zero.
- R3: Every access begins with an address phase. The request address is on the data field and the address-capture strobe is high until acknowledge is seen high. The strobe then falls and the block waits for acknowledge low.
- R4: Before any strobe rises, the data field holds the phase's value with all strobes low for at least `SETUP_CYCLES` (2) consecutive cycles. The data field does not change while a strobe is high.
- R5: A read continues with a read-strobe phase whose data field is zero. `rd_data` takes the PHY read value sampled on the poll that sees acknowledge high.
- R6: A write continues with a data-capture phase and then a write-commit phase, both carrying the write data on the data field. Each has a full acknowledge-high, acknowledge-low handshake.
- R7: At most one strobe is high at a time, and no strobe rises while acknowledge from the previous phase is still high.
- R8: Acknowledge is polled on the first cycle of a wait and then every `POLL_INTERVAL` cycles. A wait fails on its `POLL_LIMIT`-th unmatched poll, so `err` appears (`POLL_LIMIT`-1)*`POLL_INTERVAL`+1 cycles after a strobe that is never acknowledged. An acknowledge that arrives inside the window completes normally.
- R9: On a failed wait, all strobes are low, `rd_data` is zero, `err` is high for exactly one cycle and `done` is not given for that access.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the done or error cycle. A request presented while `busy` is high is ignored and causes no port activity.
- R11: `done` is a one-cycle pulse with `busy` still high. In the next cycle both are low and a new request may be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on handshake timeout |
| rd_data | output | 16 | Read result, zero after a timeout |
| cr_ctrl | output | 20 | Control word to the PHY port (strobes and data field) |
| cr_resp | input | 17 | Response word from the PHY port (acknowledge and read value) |

## Verification
The hardest situations to reach from the ports are the timeout paths. The worst is a read whose acknowledge rises, so that a value is already latched, and then never falls: the result must still come back as zero. The bench's PHY responder model can be told to hold acknowledge low or to hold it high. That allows a timeout in the high-wait and in the low-wait phases, and the cycle distance from strobe to error pulse is measured. A late but in-window acknowledge is forced through a fixed responder delay. A request is injected while busy to show that it leaves no trace on the port or in the PHY's registers.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  // Phase of one register access; the value also picks the strobe bit.
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_SETUP   = 3'd1,
    S_WAIT_HI = 3'd2,
    S_WAIT_LO = 3'd3,
    S_END     = 3'd4
  } seq_state_e;

  localparam int STB_W = 4;

endpackage

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
  parameter int POLL_INTERVAL = 250,
  parameter int POLL_LIMIT    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick,
  output logic last_poll
);
  localparam int IW = (POLL_INTERVAL < 2) ? 1 : $clog2(POLL_INTERVAL + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic [IW-1:0] ivl_q;
  logic [PW-1:0] polls_q;

  assign tick      = run && (ivl_q == '0);
  assign last_poll = (polls_q == PW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      ivl_q   <= '0;
      polls_q <= '0;
    end else if (tick) begin
      ivl_q   <= IW'(POLL_INTERVAL - 1);
      polls_q <= polls_q + 1'b1;
    end else begin
      ivl_q   <= ivl_q - 1'b1;
    end
  end

  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (polls_q < PW'(POLL_LIMIT)));

  // R8
  poll_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !clr) |=> !tick);

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
  import phy_cr_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SETUP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] phy_rdata,
  input  logic              tick,
  input  logic              last_poll,
  output logic              tmr_run,
  output logic              tmr_clr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_data,
  output logic [STB_W-1:0]  stb
);
  localparam int SCW = (SETUP_CYCLES < 2) ? 1 : $clog2(SETUP_CYCLES + 1);

  seq_state_e        st_q;
  phase_e            ph_q;
  logic [SCW-1:0]    scnt_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_q;
  logic [STB_W-1:0]  stb_q;
  logic              busy_q, done_q, err_q;
  logic              ack_match;

  always_comb begin
    tmr_run   = (st_q == S_WAIT_HI) || (st_q == S_WAIT_LO);
    ack_match = (st_q == S_WAIT_HI) ? ack : !ack;
    tmr_clr   = tmr_run && tick && ack_match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      ph_q    <= PH_ADDR;
      scnt_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      data_q  <= '0;
      rd_q    <= '0;
      stb_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            data_q  <= req_addr;
            ph_q    <= PH_ADDR;
            scnt_q  <= SCW'(SETUP_CYCLES - 1);
            busy_q  <= 1'b1;
            st_q    <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (scnt_q == '0) begin
            stb_q <= STB_W'(1) << ph_q;
            st_q  <= S_WAIT_HI;
          end else begin
            scnt_q <= scnt_q - 1'b1;
          end
        end
        S_WAIT_HI: begin
          if (tick) begin
            if (ack) begin
              if (ph_q == PH_READ) rd_q <= phy_rdata;
              stb_q <= '0;
              st_q  <= S_WAIT_LO;
            end else if (last_poll) begin
              stb_q <= '0;
              rd_q  <= '0;
              err_q <= 1'b1;
              st_q  <= S_END;
            end
          end
        end
        S_WAIT_LO: begin
          if (tick) begin
            if (!ack) begin
              unique case (ph_q)
                PH_ADDR: begin
                  ph_q   <= wr_q ? PH_DATA : PH_READ;
                  data_q <= wr_q ? wdata_q : '0;
                  scnt_q <= SCW'(SETUP_CYCLES - 1);
                  st_q   <= S_SETUP;
                end
                PH_DATA: begin
                  ph_q   <= PH_WRITE;
                  data_q <= wdata_q;
                  scnt_q <= SCW'(SETUP_CYCLES - 1);
                  st_q   <= S_SETUP;
                end
                default: begin
                  done_q <= 1'b1;
                  st_q   <= S_END;
                end
              endcase
            end else if (last_poll) begin
              rd_q  <= '0;
              err_q <= 1'b1;
              st_q  <= S_END;
            end
          end
        end
        S_END: begin
          busy_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_data  = rd_q;
  assign bus_data = data_q;
  assign stb      = stb_q;

  // R7
  stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q));

  // R4
  setup_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|stb_q) |-> ($stable(data_q) && ($past(stb_q, 2) == '0)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|stb_q && $past(|stb_q)) |-> $stable(data_q));

  // R5
  read_zero_field_chk: assert property (@(posedge clk) disable iff (rst)
    stb_q[PH_READ] |-> (data_q == '0));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ((stb_q == '0) && (rd_q == '0) && !done_q && busy_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> busy_q ##1 (!busy_q && !done_q));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_q && !err_q) |=> busy_q);

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int POLL_INTERVAL = 250,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETUP_CYCLES  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [DATA_W-1:0]   rd_data,
  output logic [DATA_W+3:0]   cr_ctrl,
  input  logic [DATA_W:0]     cr_resp
);
  localparam int ACK_BIT = DATA_W;

  logic              tick, last_poll, tmr_run, tmr_clr;
  logic [DATA_W-1:0] bus_data;
  logic [STB_W-1:0]  stb;

  phy_cr_poll_timer #(
    .POLL_INTERVAL(POLL_INTERVAL),
    .POLL_LIMIT   (POLL_LIMIT)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (tmr_run),
    .clr      (tmr_clr),
    .tick     (tick),
    .last_poll(last_poll)
  );

  phy_cr_seq #(
    .DATA_W      (DATA_W),
    .SETUP_CYCLES(SETUP_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ack      (cr_resp[ACK_BIT]),
    .phy_rdata(cr_resp[DATA_W-1:0]),
    .tick     (tick),
    .last_poll(last_poll),
    .tmr_run  (tmr_run),
    .tmr_clr  (tmr_clr),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data),
    .bus_data (bus_data),
    .stb      (stb)
  );

  // Word layout: addr-capture, data-capture, data field, read, write-commit.
  assign cr_ctrl = {stb[PH_ADDR], stb[PH_DATA], bus_data, stb[PH_READ], stb[PH_WRITE]};

endmodule

// File: tb/test_phy_cr_master.sv
module test_phy_cr_master;
  localparam int DW = 16;
  localparam int PI = 4;
  localparam int PL = 8;
  localparam int SC = 2;
  localparam int TO_LAT = (PL - 1) * PI + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write;
  logic [DW-1:0] req_addr, req_wdata;
  logic          busy, done, err;
  logic [DW-1:0] rd_data;
  logic [DW+3:0] cr_ctrl;
  logic          ack_r;
  logic [DW-1:0] dout_r;
  logic [DW:0]   cr_resp;

  always #10 clk = ~clk;
  assign cr_resp = {ack_r, dout_r};

  phy_cr_master #(.DATA_W(DW), .POLL_INTERVAL(PI), .POLL_LIMIT(PL), .SETUP_CYCLES(SC))
  i_phy_cr_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .cr_ctrl(cr_ctrl), .cr_resp(cr_resp)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model state
  logic [DW-1:0] phy_mem [16];
  logic [DW-1:0] ref_mem [16];
  logic [DW-1:0] cap_addr, cap_data;
  logic [DW+3:0] log_word [8];
  int  log_n = 0;
  int  rise_cyc = 0;
  bit  stall_hi = 0, stall_lo = 0;
  int  dly_max = 6, force_dly = -1;
  bit  setup_bad = 0, multi_bad = 0, early_bad = 0;

  function automatic logic [DW-1:0] init_word(int i);
    return 16'(i * 16'h1111) ^ 16'h5A5A;
  endfunction

  function automatic logic [DW+3:0] word(logic [3:0] s, logic [DW-1:0] d);
    return {s[3], s[2], d, s[1], s[0]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // PHY responder and port monitor
  initial begin
    logic [3:0] st, prev_st;
    logic [DW-1:0] d, prev_d;
    int cnt, dly, low_run;
    ack_r = 0; dout_r = '0; cap_addr = '0; cap_data = '0;
    cnt = 0; dly = 0; low_run = 0; prev_st = '0; prev_d = '0;
    forever begin
      @(negedge clk);
      if (rst) begin ack_r = 0; cnt = 0; continue; end
      st = {cr_ctrl[DW+3], cr_ctrl[DW+2], cr_ctrl[1], cr_ctrl[0]};
      d  = cr_ctrl[DW+1:2];
      if ($countones(st) > 1) multi_bad = 1;
      if (st != 0 && prev_st == 0) begin
        if (low_run < SC) setup_bad = 1;
        if (ack_r) early_bad = 1;
        if (log_n < 8) log_word[log_n] = cr_ctrl;
        log_n++;
        rise_cyc = cyc;
      end
      if (st == 0 && d == prev_d) low_run++;
      else if (st == 0) low_run = 1;
      else low_run = 0;
      prev_st = st; prev_d = d;
      if (st != 0 && !ack_r) begin
        if (!stall_hi) begin
          if (cnt >= dly) begin
            ack_r = 1; cnt = 0;
            if (st[3]) cap_addr = d;
            if (st[2]) cap_data = d;
            if (st[1]) dout_r = phy_mem[cap_addr[3:0]];
            if (st[0]) phy_mem[cap_addr[3:0]] = cap_data;
            dly = (force_dly >= 0) ? force_dly : int'($urandom_range(dly_max, 0));
          end else cnt++;
        end
      end else if (st == 0 && ack_r) begin
        if (!stall_lo) begin
          if (cnt >= dly) begin
            ack_r = 0; cnt = 0;
            dly = (force_dly >= 0) ? force_dly : int'($urandom_range(dly_max, 0));
          end else cnt++;
        end
      end else cnt = 0;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  // Issue one request and follow it to done or err.
  task automatic run_op(input bit wr, input logic [DW-1:0] a, input logic [DW-1:0] wd,
                        input bit inject, output bit got_done, output bit got_err,
                        output int err_cyc);
    int n;
    log_n = 0; got_done = 0; got_err = 0; err_cyc = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check("R10", "busy after accept", busy, 1);
    n = 0;
    while (!(done || err) && n < 3000) begin
      if (inject && n == 3) begin
        req_valid = 1; req_write = 1; req_addr = a ^ 16'h0005; req_wdata = 16'hDEAD;
      end else req_valid = 0;
      @(negedge clk);
      n++;
    end
    req_valid = 0;
    got_done = done; got_err = err; err_cyc = cyc;
    check("R11", "busy during end pulse", busy, 1);
    check("R9", "done and err exclusive", done && err, 0);
    @(negedge clk);
    check("R11", "busy low after end", busy, 0);
    check("R11", "done single cycle", done, 0);
    check("R9", "err single cycle", err, 0);
  endtask

  task automatic normal_op(input bit wr, input logic [DW-1:0] a, input logic [DW-1:0] wd,
                           input bit inject);
    bit gd, ge; int ec;
    setup_bad = 0; multi_bad = 0; early_bad = 0;
    run_op(wr, a, wd, inject, gd, ge, ec);
    check("R11", "done given", gd, 1);
    check("R9", "no error", ge, 0);
    check("R4", "setup window before strobe", setup_bad, 0);
    check("R7", "one strobe, no rise under ack", multi_bad | early_bad, 0);
    check("R1", "first word address capture", log_word[0], word(4'b1000, a));
    if (wr) begin
      check("R6", "write strobe count", log_n, 3);
      check("R6", "data capture word", log_word[1], word(4'b0100, wd));
      check("R6", "write commit word", log_word[2], word(4'b0001, wd));
      ref_mem[a[3:0]] = wd;
    end else begin
      check("R5", "read strobe count", log_n, 2);
      check("R5", "read strobe word, zero field", log_word[1], word(4'b0010, '0));
      check("R5", "read data", rd_data, ref_mem[a[3:0]]);
    end
  endtask

  initial begin
    bit gd, ge; int ec;
    logic [DW-1:0] a;
    void'($urandom(32'd20240613));
    for (int i = 0; i < 16; i++) begin
      phy_mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    check("R2", "ctrl word after reset", cr_ctrl, '0);
    check("R2", "busy/done/err after reset", {busy, done, err}, 3'b000);
    check("R2", "rd_data after reset", rd_data, '0);

    // R3 R5 R6 directed accesses
    normal_op(0, 16'h1003, '0, 0);
    normal_op(1, 16'h2007, 16'hBEEF, 0);
    normal_op(0, 16'h2007, '0, 0);
    normal_op(1, 16'hFFFF, 16'h0000, 0);
    normal_op(0, 16'h000F, '0, 0);

    // R10 request while busy is ignored
    normal_op(1, 16'h0102, 16'h7777, 1);
    repeat (10) @(negedge clk);
    check("R10", "no activity after ignored request", {busy, cr_ctrl[DW+3], cr_ctrl[DW+2], cr_ctrl[1], cr_ctrl[0]}, '0);
    normal_op(0, 16'h0107, '0, 0);

    // R8 late acknowledge inside the poll window
    force_dly = 20;
    normal_op(1, 16'h0309, 16'h1234, 0);
    force_dly = -1;
    normal_op(0, 16'h0309, '0, 0);

    // R8 R9 acknowledge never rises
    stall_hi = 1;
    run_op(1, 16'h0404, 16'h4444, 0, gd, ge, ec);
    check("R9", "timeout reports err", ge, 1);
    check("R9", "timeout gives no done", gd, 0);
    check("R8", "strobe to err latency", ec - rise_cyc, TO_LAT);
    check("R9", "strobes low after timeout", {cr_ctrl[DW+3], cr_ctrl[DW+2], cr_ctrl[1], cr_ctrl[0]}, 4'b0000);
    check("R9", "rd_data zero after timeout", rd_data, '0);
    stall_hi = 0;
    repeat (5) @(negedge clk);

    // R9 read with acknowledge stuck high: latched value discarded
    normal_op(0, 16'h0006, '0, 0);
    check("R5", "nonzero value before stuck test", rd_data != 0, 1);
    stall_lo = 1;
    run_op(0, 16'h000B, '0, 0, gd, ge, ec);
    check("R9", "stuck-high err", ge, 1);
    check("R9", "stuck-high rd_data zero", rd_data, '0);
    repeat (3) @(negedge clk);
    stall_lo = 0;
    repeat (30) @(negedge clk);
    check("R7", "ack released before next access", ack_r, 0);

    // Random mix
    for (int k = 0; k < 60; k++) begin
      a = 16'($urandom);
      if ($urandom_range(1, 0) == 1) normal_op(1, a, 16'($urandom), 0);
      else normal_op(0, a, '0, 0);
      repeat ($urandom_range(3, 0)) @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule